// File: doc/BRIEF.md
# Packet-Filter Virtual Machine Integer Execution Unit

This block executes one integer arithmetic instruction of a 64-bit packet-filter virtual machine per accepted request. The caller presents the 8-bit opcode, the 16-bit offset field, the 32-bit immediate and the current values of the destination and source registers, together with a valid strobe. One clock later the unit presents the 64-bit result, a write-enable for the destination register and an illegal-instruction flag. Register storage, instruction fetch, branching and memory access belong to the surrounding core.

The unit covers both the 32-bit and the 64-bit arithmetic classes: add, subtract, multiply, unsigned and signed divide and remainder, bitwise logic, three shifts, negate, plain and sign-extending moves, and byte-order conversion. Division is a single-cycle combinational datapath, so every operation has the same one-cycle latency. The byte order of the host is a parameter (`HOST_BIG`, 0 for little-endian).

Top module: `ealu_core`

## Requirements
- R1: Opcode bits [2:0] select the class: 4 is the 32-bit class, 7 is the 64-bit class, and any other value is illegal. Opcode bit 3 picks the immediate (0) or the source register (1) as second operand. Opcode bits [7:4] give the operation: ADD 0, SUB 1, MUL 2, DIV 3, OR 4, AND 5, LSH 6, RSH 7, NEG 8, MOD 9, XOR 10, MOV 11, ARSH 12, END 13.
- R2: Add, subtract, multiply, OR, AND, XOR and plain move produce their result modulo 2 to the power of the operand width.
- R3: Every legal 32-bit-class result except END has bits [63:32] equal to zero.
- R4: In the 64-bit class the immediate is sign-extended from 32 bits before use, also for unsigned divide and remainder; in the 32-bit class it is used as an unsigned 32-bit value.
- R5: Shift counts are masked to 6 bits in the 64-bit class and 5 bits in the 32-bit class; LSH and RSH fill with zeros, ARSH fills with the operand's sign bit.
- R6: A divide whose divisor is zero returns zero.
- R7: A remainder whose divisor is zero returns the destination value unchanged in the 64-bit class, and its low 32 bits with the upper half cleared in the 32-bit class.
- R8: For DIV and MOD an offset of 1 selects signed operation with truncation toward zero and a remainder carrying the dividend's sign; the most negative value divided by -1 returns the most negative value and the matching remainder is zero.
- R9: MOV with offset 8 or 16 (both classes) or 32 (64-bit class only) sign-extends the low 8, 16 or 32 bits of the second operand; the 32-bit class then clears bits [63:32].
- R10: NEG returns the two's complement of the destination value at the class width.
- R11: END takes its width from the immediate (16, 32 or 64) and returns the low bytes of the destination, zero-extended, byte-reversed when a swap is needed: always in the 64-bit class, and in the 32-bit class when opcode bit 3 (0 = to little-endian, 1 = to big-endian) names the order opposite to the host.
- R12: Operation codes 14 and 15, a nonzero offset on operations other than DIV, MOD and MOV, offsets other than 0/1 on DIV and MOD, an unsupported MOV width, an END width other than 16/32/64, an END with nonzero offset, and a 64-bit-class END with opcode bit 3 set are illegal: the flag is raised, the write-enable stays low and the result is zero.
- R13: The outputs belong to the request accepted at the previous rising clock edge; exactly one of write-enable and illegal flag is high then, and both are low when no request was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| opcode | input | 8 | Instruction opcode |
| offset | input | 16 | Instruction offset field |
| imm | input | 32 | Instruction immediate |
| dst_val | input | 64 | Current destination register value |
| src_val | input | 64 | Current source register value |
| res_val | output | 64 | Result |
| res_we | output | 1 | Destination write-enable |
| res_illegal | output | 1 | Illegal-instruction flag |

## Verification
Directed cases aim at the values where the two classes and the signed and unsigned views part ways: the most negative 32- and 64-bit numbers against -1, zero divisors in both classes, an all-ones immediate that becomes huge only after 64-bit sign extension, and shift counts one past the mask. Byte-order cases use a value with distinct bytes so that a missing swap, a wrong width or a swap where none belongs each give a different word. Random requests mix legal and illegal class, offset and width encodings with register values drawn partly from those corner numbers, so decode and datapath errors show up against the bench model.

// File: rtl/ealu_pkg.sv
package ealu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_MUL  = 4'd2,
    OP_DIV  = 4'd3,
    OP_OR   = 4'd4,
    OP_AND  = 4'd5,
    OP_LSH  = 4'd6,
    OP_RSH  = 4'd7,
    OP_NEG  = 4'd8,
    OP_MOD  = 4'd9,
    OP_XOR  = 4'd10,
    OP_MOV  = 4'd11,
    OP_ARSH = 4'd12,
    OP_END  = 4'd13
  } alu_op_e;

  typedef enum logic [1:0] {
    SW_16 = 2'd0,
    SW_32 = 2'd1,
    SW_64 = 2'd2
  } swap_w_e;

  typedef enum logic [1:0] {
    SX_NONE = 2'd0,
    SX_8    = 2'd1,
    SX_16   = 2'd2,
    SX_32   = 2'd3
  } sx_w_e;

  localparam logic [2:0] CLS_NARROW = 3'd4;
  localparam logic [2:0] CLS_WIDE   = 3'd7;

endpackage

// File: rtl/ealu_decode.sv
module ealu_decode
  import ealu_pkg::*;
#(
  parameter int DW = 64,
  parameter int IW = 32
) (
  input  logic [7:0]    opcode,
  input  logic [15:0]   offset,
  input  logic [IW-1:0] imm,
  input  logic [DW-1:0] src_val,
  output logic          is_wide,
  output logic          legal,
  output alu_op_e       op,
  output logic [DW-1:0] opnd_b,
  output logic          div_signed,
  output sx_w_e         sx_w,
  output swap_w_e       sw_w
);

  logic cls_ok;
  logic fld_ok;

  always_comb begin
    is_wide    = (opcode[2:0] == CLS_WIDE);
    cls_ok     = is_wide || (opcode[2:0] == CLS_NARROW);
    op         = alu_op_e'(opcode[7:4]);
    div_signed = (offset == 16'd1);
    opnd_b     = opcode[3] ? src_val
               : (is_wide ? {{(DW-IW){imm[IW-1]}}, imm} : {{(DW-IW){1'b0}}, imm});
    sx_w = SX_NONE;
    if (offset == 16'd8)       sx_w = SX_8;
    else if (offset == 16'd16) sx_w = SX_16;
    else if (offset == 16'd32) sx_w = SX_32;
    sw_w = SW_64;
    if (imm == IW'(16))      sw_w = SW_16;
    else if (imm == IW'(32)) sw_w = SW_32;
    unique case (opcode[7:4])
      4'd3, 4'd9: fld_ok = (offset == 16'd0) || (offset == 16'd1);
      4'd11:      fld_ok = (offset == 16'd0) || (offset == 16'd8) || (offset == 16'd16)
                        || (is_wide && offset == 16'd32);
      4'd13:      fld_ok = (offset == 16'd0) && !(is_wide && opcode[3])
                        && (imm == IW'(16) || imm == IW'(32) || imm == IW'(64));
      4'd14, 4'd15: fld_ok = 1'b0;
      default:    fld_ok = (offset == 16'd0);
    endcase
    legal = cls_ok && fld_ok;
  end

endmodule

// File: rtl/ealu_divmod.sv
module ealu_divmod #(
  parameter int DW = 64
) (
  input  logic [DW-1:0] num,
  input  logic [DW-1:0] den,
  input  logic          is_signed,
  output logic [DW-1:0] quo,
  output logic [DW-1:0] rem
);

  logic          neg_n;
  logic          neg_d;
  logic [DW-1:0] mag_n;
  logic [DW-1:0] mag_d;
  logic [DW-1:0] uq;
  logic [DW-1:0] ur;

  always_comb begin
    neg_n = is_signed && num[DW-1];
    neg_d = is_signed && den[DW-1];
    mag_n = neg_n ? (~num + 1'b1) : num;
    mag_d = neg_d ? (~den + 1'b1) : den;
    if (mag_d == '0) mag_d = {{(DW-1){1'b0}}, 1'b1};
    uq  = mag_n / mag_d;
    ur  = mag_n % mag_d;
    quo = (neg_n ^ neg_d) ? (~uq + 1'b1) : uq;
    rem = neg_n ? (~ur + 1'b1) : ur;
  end

endmodule

// File: rtl/ealu_swap.sv
module ealu_swap
  import ealu_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic [DW-1:0] val,
  input  swap_w_e       width,
  input  logic          do_swap,
  output logic [DW-1:0] out
);

  localparam int NB = DW / 8;

  logic [DW-1:0] rev [3];

  for (genvar g = 0; g < 3; g++) begin : g_width
    localparam int GB = 2 << g;
    always_comb begin
      rev[g] = '0;
      for (int i = 0; i < GB; i++) begin
        rev[g][8*i +: 8] = do_swap ? val[8*(GB-1-i) +: 8] : val[8*i +: 8];
      end
    end
  end

  always_comb begin
    unique case (width)
      SW_16:   out = rev[0];
      SW_32:   out = rev[1];
      default: out = rev[2];
    endcase
  end

  if (NB != 8) begin : g_bad_width
    initial $error("ealu_swap expects DW of 64");
  end

endmodule

// File: rtl/ealu_core.sv
module ealu_core
  import ealu_pkg::*;
#(
  parameter int DW       = 64,
  parameter int IW       = 32,
  parameter bit HOST_BIG = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [7:0]    opcode,
  input  logic [15:0]   offset,
  input  logic [IW-1:0] imm,
  input  logic [DW-1:0] dst_val,
  input  logic [DW-1:0] src_val,
  output logic [DW-1:0] res_val,
  output logic          res_we,
  output logic          res_illegal
);

  localparam int HW = DW / 2;
  localparam int SW = $clog2(DW);

  logic          is_wide;
  logic          legal;
  alu_op_e       op;
  logic [DW-1:0] b;
  logic          div_signed;
  sx_w_e         sx_w;
  swap_w_e       sw_w;
  logic [DW-1:0] div_num;
  logic [DW-1:0] div_den;
  logic [DW-1:0] quo;
  logic [DW-1:0] rem;
  logic [DW-1:0] swapped;
  logic [DW-1:0] w_res;
  logic [HW-1:0] n_res;
  logic [DW-1:0] nxt_res;
  logic [HW-1:0] a_n;
  logic [HW-1:0] b_n;

  ealu_decode #(.DW(DW), .IW(IW)) u_dec (
    .opcode(opcode), .offset(offset), .imm(imm), .src_val(src_val),
    .is_wide(is_wide), .legal(legal), .op(op), .opnd_b(b),
    .div_signed(div_signed), .sx_w(sx_w), .sw_w(sw_w)
  );

  always_comb begin
    a_n = dst_val[HW-1:0];
    b_n = b[HW-1:0];
    if (is_wide) begin
      div_num = dst_val;
      div_den = b;
    end else if (div_signed) begin
      div_num = {{HW{a_n[HW-1]}}, a_n};
      div_den = {{HW{b_n[HW-1]}}, b_n};
    end else begin
      div_num = {{HW{1'b0}}, a_n};
      div_den = {{HW{1'b0}}, b_n};
    end
  end

  ealu_divmod #(.DW(DW)) u_div (
    .num(div_num), .den(div_den), .is_signed(div_signed),
    .quo(quo), .rem(rem)
  );

  ealu_swap #(.DW(DW)) u_swap (
    .val(dst_val), .width(sw_w),
    .do_swap(is_wide || (opcode[3] != HOST_BIG)),
    .out(swapped)
  );

  // 64-bit class datapath
  always_comb begin
    unique case (op)
      OP_ADD:  w_res = dst_val + b;
      OP_SUB:  w_res = dst_val - b;
      OP_MUL:  w_res = dst_val * b;
      OP_DIV:  w_res = (b == '0) ? '0 : quo;
      OP_OR:   w_res = dst_val | b;
      OP_AND:  w_res = dst_val & b;
      OP_LSH:  w_res = dst_val << b[SW-1:0];
      OP_RSH:  w_res = dst_val >> b[SW-1:0];
      OP_NEG:  w_res = '0 - dst_val;
      OP_MOD:  w_res = (b == '0) ? dst_val : rem;
      OP_XOR:  w_res = dst_val ^ b;
      OP_ARSH: w_res = DW'($signed(dst_val) >>> b[SW-1:0]);
      OP_MOV: begin
        unique case (sx_w)
          SX_8:    w_res = {{(DW-8){b[7]}}, b[7:0]};
          SX_16:   w_res = {{(DW-16){b[15]}}, b[15:0]};
          SX_32:   w_res = {{(DW-32){b[31]}}, b[31:0]};
          default: w_res = b;
        endcase
      end
      default: w_res = '0;
    endcase
  end

  // 32-bit class datapath
  always_comb begin
    unique case (op)
      OP_ADD:  n_res = a_n + b_n;
      OP_SUB:  n_res = a_n - b_n;
      OP_MUL:  n_res = a_n * b_n;
      OP_DIV:  n_res = (b_n == '0) ? '0 : quo[HW-1:0];
      OP_OR:   n_res = a_n | b_n;
      OP_AND:  n_res = a_n & b_n;
      OP_LSH:  n_res = a_n << b_n[SW-2:0];
      OP_RSH:  n_res = a_n >> b_n[SW-2:0];
      OP_NEG:  n_res = '0 - a_n;
      OP_MOD:  n_res = (b_n == '0) ? a_n : rem[HW-1:0];
      OP_XOR:  n_res = a_n ^ b_n;
      OP_ARSH: n_res = HW'($signed(a_n) >>> b_n[SW-2:0]);
      OP_MOV: begin
        unique case (sx_w)
          SX_8:    n_res = {{(HW-8){b_n[7]}}, b_n[7:0]};
          SX_16:   n_res = {{(HW-16){b_n[15]}}, b_n[15:0]};
          default: n_res = b_n;
        endcase
      end
      default: n_res = '0;
    endcase
  end

  always_comb begin
    if (!legal)              nxt_res = '0;
    else if (op == OP_END)   nxt_res = swapped;
    else if (is_wide)        nxt_res = w_res;
    else                     nxt_res = {{HW{1'b0}}, n_res};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_val     <= '0;
      res_we      <= 1'b0;
      res_illegal <= 1'b0;
    end else begin
      res_we      <= in_valid && legal;
      res_illegal <= in_valid && !legal;
      if (in_valid) res_val <= nxt_res;
    end
  end

endmodule

// File: rtl/ealu_core_chk.sv
module ealu_core_chk #(
  parameter int DW = 64,
  parameter int IW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [7:0]    opcode,
  input logic [DW-1:0] dst_val,
  input logic [DW-1:0] src_val,
  input logic [DW-1:0] res_val,
  input logic          res_we,
  input logic          res_illegal
);

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid) |-> (res_we != res_illegal)); // R13

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> (!res_we && !res_illegal)); // R13

  AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_valid) && $past(opcode[2:0]) == 3'd4 && $past(opcode[7:4]) != 4'd13)
      |-> (res_val[DW-1:DW/2] == '0)); // R3

  AST_DIV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_valid && opcode == 8'h3f && src_val == '0) && res_we) |-> (res_val == '0)); // R6

  AST_MOD_ZERO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_valid && opcode == 8'h9f && src_val == '0) && res_we)
      |-> (res_val == $past(dst_val))); // R7

  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    res_illegal |-> (!res_we && res_val == '0)); // R12

endmodule

bind ealu_core ealu_core_chk #(.DW(DW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
  .dst_val(dst_val), .src_val(src_val), .res_val(res_val),
  .res_we(res_we), .res_illegal(res_illegal)
);

// File: tb/test_ealu_core.sv
`timescale 1ns/1ps
module test_ealu_core;

  localparam bit HOST_BIG = 1'b0;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [7:0]  opcode;
  logic [15:0] offset;
  logic [31:0] imm;
  logic [63:0] dst_val;
  logic [63:0] src_val;
  logic [63:0] res_val;
  logic        res_we;
  logic        res_illegal;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  ealu_core #(.DW(64), .IW(32), .HOST_BIG(HOST_BIG)) i_ealu_core (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .offset(offset), .imm(imm), .dst_val(dst_val), .src_val(src_val),
    .res_val(res_val), .res_we(res_we), .res_illegal(res_illegal)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Independent model: returns {we, illegal, result}
  function automatic logic [65:0] ref_model(input logic [7:0] op, input logic [15:0] off,
      input logic [31:0] im, input logic [63:0] d, input logic [63:0] s);
    logic        w;
    logic        ok;
    logic [63:0] msk;
    logic [63:0] b;
    logic [63:0] r;
    logic [63:0] dm;
    logic [63:0] bm;
    logic [63:0] sd;
    logic [63:0] sb;
    int          amt;
    int          nb;
    logic        sw;
    w   = (op[2:0] == 3'd7);
    ok  = w || (op[2:0] == 3'd4);
    msk = w ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
    b   = op[3] ? s : (w ? {{32{im[31]}}, im} : {32'd0, im});
    dm  = d & msk;
    bm  = b & msk;
    sd  = w ? d : {{32{d[31]}}, d[31:0]};
    sb  = w ? b : {{32{b[31]}}, b[31:0]};
    amt = w ? int'(b[5:0]) : int'(b[4:0]);
    r   = 64'd0;
    case (op[7:4])
      4'd0:  begin ok = ok && off == 0; r = (d + b) & msk; end
      4'd1:  begin ok = ok && off == 0; r = (d - b) & msk; end
      4'd2:  begin ok = ok && off == 0; r = (d * b) & msk; end
      4'd4:  begin ok = ok && off == 0; r = (d | b) & msk; end
      4'd5:  begin ok = ok && off == 0; r = (d & b) & msk; end
      4'd10: begin ok = ok && off == 0; r = (d ^ b) & msk; end
      4'd6:  begin ok = ok && off == 0; r = (d << amt) & msk; end
      4'd7:  begin ok = ok && off == 0; r = dm >> amt; end
      4'd12: begin ok = ok && off == 0; r = 64'($signed(sd) >>> amt) & msk; end
      4'd8:  begin ok = ok && off == 0; r = (64'd0 - d) & msk; end
      4'd3: begin
        ok = ok && (off == 0 || off == 1);
        if (bm == 0) r = 0;
        else if (off == 0) r = dm / bm;
        else if (sb == 64'hFFFF_FFFF_FFFF_FFFF) r = (64'd0 - sd) & msk;
        else r = 64'($signed(sd) / $signed(sb)) & msk;
      end
      4'd9: begin
        ok = ok && (off == 0 || off == 1);
        if (bm == 0) r = dm;
        else if (off == 0) r = dm % bm;
        else if (sb == 64'hFFFF_FFFF_FFFF_FFFF) r = 0;
        else r = 64'($signed(sd) % $signed(sb)) & msk;
      end
      4'd11: begin
        ok = ok && (off == 0 || off == 8 || off == 16 || (w && off == 32));
        if (off == 8)       r = {{56{b[7]}}, b[7:0]} & msk;
        else if (off == 16) r = {{48{b[15]}}, b[15:0]} & msk;
        else if (off == 32) r = {{32{b[31]}}, b[31:0]};
        else                r = bm;
      end
      4'd13: begin
        ok = ok && off == 0 && (im == 16 || im == 32 || im == 64) && !(w && op[3]);
        nb = int'(im) / 8;
        sw = w || (op[3] != HOST_BIG);
        if (ok) for (int i = 0; i < nb; i++) r[8*i +: 8] = sw ? d[8*(nb-1-i) +: 8] : d[8*i +: 8];
      end
      default: ok = 1'b0;
    endcase
    if (!ok) r = 64'd0;
    return {ok, !ok, r};
  endfunction

  // Drive one request at a falling edge, compare one cycle later
  task automatic issue(input logic [7:0] op, input logic [15:0] off, input logic [31:0] im,
      input logic [63:0] d, input logic [63:0] s, input logic [65:0] exp, input string tag);
    in_valid = 1'b1; opcode = op; offset = off; imm = im; dst_val = d; src_val = s;
    @(negedge clk);
    n_checks++;
    if ({res_we, res_illegal, res_val} !== exp) begin
      n_fail++;
      $display("FAIL %s op=%h off=%0d imm=%h d=%h s=%h: got we=%b ill=%b res=%h expected we=%b ill=%b res=%h",
               tag, op, off, im, d, s, res_we, res_illegal, res_val, exp[65], exp[64], exp[63:0]);
    end
    in_valid = 1'b0;
  endtask

  task automatic dir(input logic [7:0] op, input logic [15:0] off, input logic [31:0] im,
      input logic [63:0] d, input logic [63:0] s, input logic [63:0] r, input string tag);
    issue(op, off, im, d, s, {1'b1, 1'b0, r}, tag);
  endtask

  task automatic bad(input logic [7:0] op, input logic [15:0] off, input logic [31:0] im,
      input string tag);
    issue(op, off, im, 64'h1234, 64'h5678, {1'b0, 1'b1, 64'd0}, tag);
  endtask

  function automatic logic [63:0] pick_val();
    case ($urandom % 8)
      0: return 64'd0;
      1: return 64'hFFFF_FFFF_FFFF_FFFF;
      2: return 64'h8000_0000_0000_0000;
      3: return 64'h0000_0000_8000_0000;
      4: return 64'(($urandom % 70));
      default: return {$urandom, $urandom};
    endcase
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_valid = 1'b0; opcode = '0; offset = '0; imm = '0;
    dst_val = '0; src_val = '0;
    repeat (3) @(negedge clk);
    n_checks++;
    if (res_we !== 1'b0 || res_illegal !== 1'b0 || res_val !== 64'd0) begin
      n_fail++;
      $display("FAIL R13 reset: got we=%b ill=%b res=%h expected 0 0 0", res_we, res_illegal, res_val);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R1 source selection and class
    dir(8'h07, 0, 32'd5, 64'd10, 64'd7, 64'd15, "R1 imm operand");
    dir(8'h0f, 0, 32'd5, 64'd10, 64'd7, 64'd17, "R1 reg operand");
    bad(8'h05, 0, 32'd0, "R1 non-ALU class");
    // R2 / R3 wrap and upper clear
    dir(8'h0c, 0, 0, 64'h1_FFFF_FFFF, 64'd1, 64'd0, "R2 R3 32-bit add wrap");
    dir(8'h1f, 0, 0, 64'd0, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, "R2 64-bit sub wrap");
    // R4 immediate extension
    dir(8'h37, 0, 32'hFFFF_FFFF, 64'd100, 0, 64'd0, "R4 wide imm sext for udiv");
    dir(8'h34, 0, 32'hFFFF_FFFF, 64'hFFFF_FFFF, 0, 64'd1, "R4 narrow imm zext");
    // R5 shifts
    dir(8'h64, 0, 32'd33, 64'd1, 0, 64'd2, "R5 narrow shift mask");
    dir(8'h67, 0, 32'd65, 64'd1, 0, 64'd2, "R5 wide shift mask");
    dir(8'hc4, 0, 32'd4, 64'h8000_0000, 0, 64'hF800_0000, "R5 narrow arsh");
    dir(8'hc7, 0, 32'd4, 64'h8000_0000_0000_0000, 0, 64'hF800_0000_0000_0000, "R5 wide arsh");
    dir(8'h74, 0, 32'd4, 64'hFFFF_FFFF_8000_0000, 0, 64'h0800_0000, "R5 narrow rsh");
    // R6 / R7 zero divisor
    dir(8'h3f, 0, 0, 64'd55, 64'd0, 64'd0, "R6 divide by zero");
    dir(8'h3c, 1, 0, 64'd55, 64'hFFFF_FFFF_0000_0000, 64'd0, "R6 narrow signed div by zero");
    dir(8'h9c, 0, 0, 64'hAAAA_BBBB_CCCC_DDDD, 64'd0, 64'h0000_0000_CCCC_DDDD, "R7 narrow mod by zero");
    dir(8'h9f, 0, 0, 64'hAAAA_BBBB_CCCC_DDDD, 64'd0, 64'hAAAA_BBBB_CCCC_DDDD, "R7 wide mod by zero");
    // R8 signed division
    dir(8'h3f, 1, 0, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, "R8 min div -1");
    dir(8'h9f, 1, 0, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, "R8 min mod -1");
    dir(8'h3c, 1, 0, 64'h8000_0000, 64'hFFFF_FFFF, 64'h8000_0000, "R8 narrow min div -1");
    dir(8'h3f, 1, 0, -64'sd7, 64'd2, 64'hFFFF_FFFF_FFFF_FFFD, "R8 truncating quotient");
    dir(8'h9f, 1, 0, -64'sd7, 64'd2, 64'hFFFF_FFFF_FFFF_FFFF, "R8 remainder sign");
    // R9 sign-extending move
    dir(8'hbf, 8, 0, 0, 64'h80, 64'hFFFF_FFFF_FFFF_FF80, "R9 wide movsx 8");
    dir(8'hbc, 16, 0, 0, 64'h8000, 64'h0000_0000_FFFF_8000, "R9 narrow movsx 16");
    dir(8'hbf, 32, 0, 0, 64'h8000_0000, 64'hFFFF_FFFF_8000_0000, "R9 wide movsx 32");
    bad(8'hbc, 32, 0, "R9 narrow movsx 32 illegal");
    // R10 negate
    dir(8'h87, 0, 0, 64'd1, 0, 64'hFFFF_FFFF_FFFF_FFFF, "R10 wide neg");
    dir(8'h84, 0, 0, 64'd1, 0, 64'h0000_0000_FFFF_FFFF, "R10 narrow neg");
    // R11 byte order
    dir(8'hd4, 0, 32'd16, 64'h1122_3344_5566_7788, 0, 64'h7788, "R11 to host order truncates");
    dir(8'hdc, 0, 32'd16, 64'h1122_3344_5566_7788, 0, 64'h8877, "R11 to other order 16");
    dir(8'hdc, 0, 32'd64, 64'h1122_3344_5566_7788, 0, 64'h8877_6655_4433_2211, "R11 to other order 64");
    dir(8'hd7, 0, 32'd32, 64'h1122_3344_5566_7788, 0, 64'h8877_6655, "R11 wide unconditional swap");
    bad(8'hdf, 0, 32'd32, "R11 R12 wide end with bit3");
    bad(8'hd4, 0, 32'd24, "R11 R12 bad end width");
    // R12 illegal encodings
    bad(8'he7, 0, 0, "R12 op 14");
    bad(8'hf4, 0, 0, "R12 op 15");
    bad(8'h07, 1, 0, "R12 add with offset");
    bad(8'h37, 2, 0, "R12 div with offset 2");
    // R13 idle cycle
    @(negedge clk);
    n_checks++;
    if (res_we !== 1'b0 || res_illegal !== 1'b0) begin
      n_fail++;
      $display("FAIL R13 idle: got we=%b ill=%b expected 0 0", res_we, res_illegal);
    end

    // Constrained random against the model (all requirements)
    for (int k = 0; k < 4000; k++) begin
      logic [3:0]  c;
      logic [2:0]  cl;
      logic [7:0]  op;
      logic [15:0] off;
      logic [31:0] im;
      logic [63:0] d;
      logic [63:0] s;
      c  = 4'($urandom % 16);
      cl = ($urandom % 10 == 0) ? 3'($urandom % 8) : (($urandom % 2) ? 3'd7 : 3'd4);
      op = {c, 1'($urandom % 2), cl};
      off = ($urandom % 12 == 0) ? 16'd1 : 16'd0;
      if (c == 4'd3 || c == 4'd9) off = ($urandom % 10 == 0) ? 16'd2 : 16'($urandom % 2);
      if (c == 4'd11) begin
        case ($urandom % 5)
          0: off = 16'd8;
          1: off = 16'd16;
          2: off = 16'd32;
          3: off = 16'd5;
          default: off = 16'd0;
        endcase
      end
      im = 32'(pick_val());
      if (c == 4'd13) begin
        case ($urandom % 4)
          0: im = 32'd16;
          1: im = 32'd32;
          2: im = 32'd64;
          default: im = 32'd24;
        endcase
      end
      d = pick_val();
      s = pick_val();
      issue(op, off, im, d, s, ref_model(op, off, im, d, s), "R1-R13 random");
      if ($urandom % 16 == 0) @(negedge clk);
    end

    summary();
  end

endmodule